// File: doc/BRIEF.md
# Aging-Adaptive Reduced-Precision Multiply-Accumulate Unit

This block multiplies streams of unsigned 8-bit activations and weights and sums the products onto a bias. It belongs in an inference datapath whose logic slows down as the silicon ages. A fixed timing margin would cost speed for the whole life of the part. Instead, the block lets a controller cut the effective width of each operand at run time. Two 3-bit amounts set the cut: `alpha` for the activation and `beta` for the weight. The narrower product then settles within the shorter critical path that is still available.

There are two ways to narrow an operand. In low-side mode the operand is shifted right by its amount, so the dropped low bits are treated as zeros. The finished sum is then shifted left by `alpha+beta` to return it to the original scale. In high-side mode the operand keeps its scale but is clamped to the largest value its reduced width can hold. No rescale is applied in this mode.

An accumulation begins with a start pulse. That pulse loads the bias and captures the configuration. Operand beats follow, each marked by a valid. The beat that carries the last flag produces a registered result in the next cycle. The accumulator saturates instead of wrapping. The block does not decide when to narrow, or by how much.

Top module: `aging_mac`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_valid` is 0 and `res_data` is 0.
- R2: A start pulse loads `bias` into the accumulator. With `in_valid` low in the start cycle, a later single beat carrying `in_last` produces `bias + act*wgt`.
- R3: With `alpha = beta = 0` in either mode, the result is exactly `bias` plus the sum of all `act*wgt` products over valid beats.
- R4: With `pad_msb = 0` (low-side mode), each activation is used as `act >> alpha` and each weight as `wgt >> beta`. The result is `(bias + sum of products) << (alpha+beta)`.
- R5: With `pad_msb = 1` (high-side mode), each activation is used as `min(act, 2^(8-alpha)-1)` and each weight as `min(wgt, 2^(8-beta)-1)`. The result is `bias + sum of products`, with no shift.
- R6: `alpha`, `beta` and `pad_msb` are sampled only in a cycle where `start` is 1. Changing them during an accumulation has no effect on its result.
- R7: The accumulator is ACC_W bits wide and saturates at 2^ACC_W-1 instead of wrapping. The output is then that saturated value, shifted as in R4 or R5.
- R8: `res_valid` is a one-cycle pulse in the cycle after a beat with both `in_valid` and `in_last` is sampled. `res_data` holds its value until the next result.
- R9: Cycles with `in_valid` low leave the accumulator unchanged, whatever is on the operand inputs.
- R10: `in_last` is ignored when `in_valid` is low. It produces no `res_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an accumulation: load the bias and capture the configuration |
| cfg_alpha | input | 3 | Number of bits dropped from the activation |
| cfg_beta | input | 3 | Number of bits dropped from the weight |
| cfg_pad_msb | input | 1 | 0 = low-side (shift) mode, 1 = high-side (clamp) mode |
| bias | input | 16 | Unsigned bias added at start |
| in_valid | input | 1 | Operand beat is valid |
| in_act | input | 8 | Unsigned activation |
| in_wgt | input | 8 | Unsigned weight |
| in_last | input | 1 | Final beat of the accumulation |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | ACC_W+14 (46) | Rescaled accumulated result |

## Verification
A wrong captured configuration, or a corrupted accumulator, stays hidden until the end of the accumulation. It appears on `res_data` in the single cycle after the last beat, together with the `res_valid` pulse. The bench therefore compares every result against an independent model. It also confirms that the pulse and the held value are correct in the cycle after that.

Some faults affect only the configuration in use at start, or only operand values that are otherwise ignored. To expose these, the streams change the configuration in the middle of an accumulation. They also insert idle beats that carry junk operands and a stray last flag.

A saturation fault shows only after enough large products have been summed. For that reason the bench runs the accumulator with a narrow width, so that it overflows within a few beats.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int OP_W      = 8;
    localparam int CFG_W     = 3;
    localparam int BIAS_W    = 16;
    localparam int SHIFT_MAX = (1 << CFG_W) - 1;
    localparam int SHIFT_W   = CFG_W + 1;
    localparam int PROD_W    = 2 * OP_W;

    typedef enum logic {
        PAD_LOW  = 1'b0,
        PAD_HIGH = 1'b1
    } pad_e;

    typedef struct packed {
        logic [CFG_W-1:0] alpha;
        logic [CFG_W-1:0] beta;
        pad_e             pad;
    } cfg_t;

    // Total left shift applied to the finished sum.
    function automatic logic [SHIFT_W-1:0] rescale_amount(cfg_t c);
        if (c.pad == PAD_HIGH)
            return '0;
        return SHIFT_W'(c.alpha) + SHIFT_W'(c.beta);
    endfunction
endpackage

// File: rtl/mac_operand_reducer.sv
module mac_operand_reducer
    import mac_pkg::*;
#(
    parameter int W  = OP_W,
    parameter int SW = CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  op_in,
    input  logic [SW-1:0] drop,
    input  pad_e          pad,
    output logic [W-1:0]  op_out
);
    // lim = 2^(W-drop): one past the largest value the reduced width can hold
    logic [W:0]   lim;
    logic [W-1:0] red_max;
    logic [W-1:0] shifted;
    logic [W-1:0] clamped;

    always_comb begin
        lim     = {1'b1, {W{1'b0}}} >> drop;
        red_max = W'(lim - (W+1)'(1));
        shifted = op_in >> drop;
        clamped = (op_in > red_max) ? red_max : op_in;
        op_out  = (pad == PAD_HIGH) ? clamped : shifted;
    end

    // R4/R5: narrowing never enlarges the operand
    a_r4_no_growth: assert property (@(posedge clk) disable iff (rst)
        op_out <= op_in);

    // R5: the reduced operand fits the reduced width
    a_r5_in_range: assert property (@(posedge clk) disable iff (rst)
        {1'b0, op_out} < ({1'b1, {W{1'b0}}} >> drop));
endmodule

// File: rtl/mac_accumulator.sv
module mac_accumulator
    import mac_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [BIAS_W-1:0] bias,
    input  logic              add_en,
    input  logic [PROD_W-1:0] addend,
    output logic [ACC_W-1:0]  acc,
    output logic [ACC_W-1:0]  acc_next
);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic [ACC_W-1:0] base;
    logic [ACC_W:0]   sum;

    always_comb begin
        base = clear ? ACC_W'(bias) : acc;
        sum  = {1'b0, base} + (ACC_W+1)'(add_en ? addend : '0);
        acc_next = sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (clear || add_en)
            acc <= acc_next;
    end

    // R7: once saturated, the accumulator stays saturated until a new start
    a_r7_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_MAX && !clear) |=> acc == ACC_MAX);

    // R9: without a new start, the accumulator never goes down
    a_r9_monotone: assert property (@(posedge clk) disable iff (rst)
        !clear |=> acc >= $past(acc));
endmodule

// File: rtl/mac_rescaler.sv
module mac_rescaler
    import mac_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int OUT_W = ACC_W + 2 * SHIFT_MAX
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [ACC_W-1:0]   acc_final,
    input  logic [SHIFT_W-1:0] shamt,
    output logic               res_valid,
    output logic [OUT_W-1:0]   res_data
);
    logic [OUT_W-1:0] scaled;

    always_comb scaled = OUT_W'(acc_final) << shamt;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= fire;
            if (fire)
                res_data <= scaled;
        end
    end

    // R8: a result pulse always follows a final beat
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(fire));

    // R8: the result holds between final beats
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(res_data));
endmodule

// File: rtl/aging_mac.sv
module aging_mac
    import mac_pkg::*;
#(
    parameter int ACC_W = 32,
    localparam int OUT_W = ACC_W + 2 * SHIFT_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CFG_W-1:0]  cfg_alpha,
    input  logic [CFG_W-1:0]  cfg_beta,
    input  logic              cfg_pad_msb,
    input  logic [BIAS_W-1:0] bias,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_act,
    input  logic [OP_W-1:0]   in_wgt,
    input  logic              in_last,
    output logic              res_valid,
    output logic [OUT_W-1:0]  res_data
);
    cfg_t              cfg_in;
    cfg_t              cfg_q;
    cfg_t              cfg_eff;
    logic [OP_W-1:0]   act_red;
    logic [OP_W-1:0]   wgt_red;
    logic [PROD_W-1:0] product;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  acc_next;
    logic              fire;

    always_comb begin
        cfg_in.alpha = cfg_alpha;
        cfg_in.beta  = cfg_beta;
        cfg_in.pad   = pad_e'(cfg_pad_msb);
        cfg_eff      = start ? cfg_in : cfg_q;
        product      = PROD_W'(act_red) * PROD_W'(wgt_red);
        fire         = in_valid && in_last;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (start)
            cfg_q <= cfg_in;
    end

    mac_operand_reducer #(.W(OP_W), .SW(CFG_W)) u_red_act (
        .clk    (clk),
        .rst    (rst),
        .op_in  (in_act),
        .drop   (cfg_eff.alpha),
        .pad    (cfg_eff.pad),
        .op_out (act_red)
    );

    mac_operand_reducer #(.W(OP_W), .SW(CFG_W)) u_red_wgt (
        .clk    (clk),
        .rst    (rst),
        .op_in  (in_wgt),
        .drop   (cfg_eff.beta),
        .pad    (cfg_eff.pad),
        .op_out (wgt_red)
    );

    mac_accumulator #(.ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .bias     (bias),
        .add_en   (in_valid),
        .addend   (product),
        .acc      (acc),
        .acc_next (acc_next)
    );

    mac_rescaler #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .acc_final (acc_next),
        .shamt     (rescale_amount(cfg_eff)),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    // R6: the captured configuration changes only on a start pulse
    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(cfg_q));

    // R10: no result pulse without a valid final beat
    a_r10_last_gated: assert property (@(posedge clk) disable iff (rst)
        (in_last && !in_valid) |=> !res_valid);
endmodule

// File: tb/tb_aging_mac.sv
module tb_aging_mac;
    localparam int ACC_W = 20;
    localparam int OUT_W = ACC_W + 14;
    localparam longint ACC_MAX = (64'sd1 <<< ACC_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [2:0]       cfg_alpha = '0;
    logic [2:0]       cfg_beta = '0;
    logic             cfg_pad_msb = 1'b0;
    logic [15:0]      bias = '0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_act = '0;
    logic [7:0]       in_wgt = '0;
    logic             in_last = 1'b0;
    logic             res_valid;
    logic [OUT_W-1:0] res_data;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    aging_mac #(.ACC_W(ACC_W)) dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_alpha(cfg_alpha), .cfg_beta(cfg_beta), .cfg_pad_msb(cfg_pad_msb),
        .bias(bias), .in_valid(in_valid), .in_act(in_act), .in_wgt(in_wgt),
        .in_last(in_last), .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(string req, longint got, longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic longint narrow(int v, int s, bit msb);
        int mx = (1 << (8 - s)) - 1;
        if (msb) return (v > mx) ? mx : v;
        return v >> s;
    endfunction

    task automatic idle_inputs();
        start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        in_act = 8'h00; in_wgt = 8'h00;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", longint'(res_valid), 0);
        check("R1 data in reset", longint'(res_data), 0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        check("R1 valid after reset", longint'(res_valid), 0);
        check("R1 data after reset", longint'(res_data), 0);
    endtask

    task automatic run_stream(string req, int a, int b, bit msb, int bv, int n,
                              int seed, bit allmax, bit poke, bit bubbles);
        longint acc = bv;
        longint exp;
        for (int i = 0; i < n; i++) begin
            int av = allmax ? 255 : ((i * 73 + seed * 29 + 11) % 256);
            int wv = allmax ? 255 : ((i * 151 + seed * 7 + 5) % 256);
            @(negedge clk);
            start = (i == 0);
            bias = 16'(bv);
            if (poke && i > 0) begin
                cfg_alpha = 3'(~a); cfg_beta = 3'(~b); cfg_pad_msb = ~msb;
            end else begin
                cfg_alpha = 3'(a); cfg_beta = 3'(b); cfg_pad_msb = msb;
            end
            in_valid = 1'b1;
            in_act = 8'(av); in_wgt = 8'(wv);
            in_last = (i == n - 1);
            acc = acc + narrow(av, a, msb) * narrow(wv, b, msb);
            if (acc > ACC_MAX) acc = ACC_MAX;
            if (bubbles && i < n - 1) begin
                @(negedge clk);
                start = 1'b0; in_valid = 1'b0; in_last = 1'b1;
                in_act = 8'hFF; in_wgt = 8'hFF;
                @(posedge clk); #1;
                check("R10 stray last", longint'(res_valid), 0);
            end
        end
        exp = msb ? acc : (acc << (a + b));
        @(posedge clk); #1;
        check({req, " R8 pulse"}, longint'(res_valid), 1);
        check(req, longint'(res_data), exp);
        @(negedge clk) idle_inputs();
        @(posedge clk); #1;
        check("R8 pulse ends", longint'(res_valid), 0);
        check("R8 data held", longint'(res_data), exp);
    endtask

    task automatic test_bias_load();
        @(negedge clk);
        start = 1'b1; in_valid = 1'b0; bias = 16'd1234;
        cfg_alpha = 3'd0; cfg_beta = 3'd0; cfg_pad_msb = 1'b0;
        in_act = 8'd200; in_wgt = 8'd200;
        @(negedge clk);
        start = 1'b0; bias = 16'd9; in_valid = 1'b1; in_act = 8'd7; in_wgt = 8'd9; in_last = 1'b1;
        @(posedge clk); #1;
        check("R2 bias load", longint'(res_data), 1234 + 63);
        @(negedge clk) idle_inputs();
        @(posedge clk); #1;
    endtask

    initial begin
        test_reset();
        test_bias_load();
        run_stream("R3 full precision", 0, 0, 1'b0, 500, 6, 1, 1'b0, 1'b0, 1'b0);
        run_stream("R3 full precision high", 0, 0, 1'b1, 77, 5, 2, 1'b0, 1'b0, 1'b0);
        run_stream("R4 low-side a2 b1", 2, 1, 1'b0, 300, 7, 3, 1'b0, 1'b0, 1'b0);
        run_stream("R4 low-side a7 b7", 7, 7, 1'b0, 3, 4, 4, 1'b1, 1'b0, 1'b0);
        run_stream("R5 high-side a3 b2", 3, 2, 1'b1, 10, 8, 5, 1'b0, 1'b0, 1'b0);
        run_stream("R5 high-side a7 b0", 7, 0, 1'b1, 0, 5, 6, 1'b1, 1'b0, 1'b0);
        run_stream("R6 cfg change ignored", 1, 3, 1'b0, 40, 6, 7, 1'b0, 1'b1, 1'b0);
        run_stream("R6 cfg change ignored high", 4, 1, 1'b1, 40, 6, 8, 1'b0, 1'b1, 1'b0);
        run_stream("R7 saturate", 0, 0, 1'b0, 65535, 20, 0, 1'b1, 1'b0, 1'b0);
        run_stream("R7 saturate shifted", 1, 1, 1'b0, 65535, 70, 0, 1'b1, 1'b0, 1'b0);
        run_stream("R9 idle beats ignored", 1, 2, 1'b0, 99, 5, 9, 1'b0, 1'b0, 1'b1);
        run_stream("R3 after saturation", 0, 0, 1'b0, 1, 3, 10, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule